// File: doc/BRIEF.md
# Accumulator Processor Core

A compact multicycle processor that keeps one 16-bit accumulator as the implied operand of every instruction. Each instruction word carries a 10-bit operand field, an opcode and an addressing flag. The core steps through fetch, decode and execute states and takes two to four clock cycles per instruction. It contains a program counter that can reload and add two in the same cycle, a registered memory address, an instruction/data capture register, the accumulator, a five-function ALU and the internal address multiplexing.

The core sees memory as a byte-addressed space of 16-bit words. It presents a registered address, a registered write-data word (the accumulator) and a 2-bit operation code. Read data must come back combinationally in the same cycle as the read request. Typical use is a small sequencer that runs short programs from an attached RAM. The bench checks the core with a division routine based on repeated subtraction.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_op` is 00 (idle) and `mem_addr` is 0. The first instruction fetch (`mem_op` 01 at address 0) occurs in the third cycle after reset release.
- R2: Instruction word layout: bits 9..0 are the operand X, bits 12..10 select the operation, and bits 15..13 are ignored. Bit 15 is an indirect flag that is always treated as clear. Selector codes: 000 complement, 001 shift right, 010 branch if negative, 011 jump, 100 store, 101 load, 110 AND, 111 ADD.
- R3: AND and ADD combine the accumulator with X, zero-extended to 16 bits. Each takes 2 cycles from its fetch to the next fetch.
- R4: Complement replaces the accumulator with its bitwise inverse. Shift right moves it one bit right and keeps bit 15 (arithmetic shift). Each takes 2 cycles.
- R5: Load issues a read (01) at byte address X in the third cycle of the instruction and places the word in the accumulator. It takes 4 cycles.
- R6: Store issues a write (10) at byte address X with the accumulator on `mem_wdata` in the third cycle of the instruction. The cycle before the write is idle. It takes 3 cycles.
- R7: Branch if negative jumps to X when accumulator bit 15 is 1 (3 cycles). Otherwise it falls through to the next word, PC+2 (2 cycles).
- R8: Jump continues fetching at X after 2 cycles. A jump to its own address repeats its fetch every 2 cycles.
- R9: `mem_op` never takes the value 11, and every write is followed directly by an instruction fetch.
- R10: A repeated-subtraction division program leaves the correct quotient and remainder in memory for any dividend 0..1023 and divisor 1..1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 10 | Registered byte address of the current memory operation |
| mem_op | output | 2 | Memory operation: 00 idle, 01 read, 10 write |
| mem_wdata | output | 16 | Write data; the accumulator value |
| mem_rdata | input | 16 | Read data, valid in the same cycle as a read |

## Verification
The internal state is visible only through the address and operation traffic, so a wrong state shows up at the ports quickly. A faulty PC or decode shows as a fetch from the wrong address, or a fetch in the wrong cycle, within one instruction. A wrong accumulator value remains hidden until the next store puts it on `mem_wdata`, or until a branch takes the wrong path. For that reason the directed program stores the accumulator after every arithmetic step and checks the cycle of every fetch. The division sweep then checks long instruction sequences through their final memory contents.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [3:0] {
    S_RST1, S_RST2, S_FETCH, S_AOPR, S_SOPR, S_ST1, S_ST2,
    S_LD1, S_LD2, S_LD3, S_BRN1, S_BRN2, S_JMP
  } state_t;

  typedef enum logic [2:0] {ALU_PASSA, ALU_NOTB, ALU_AND, ALU_ADD, ALU_SHRB} alu_op_t;
  typedef enum logic [1:0] {PC_HOLD, PC_ZERO, PC_INC, PC_LDINC} pc_sel_t;

  localparam logic [1:0] MOP_NOP = 2'b00;
  localparam logic [1:0] MOP_RD  = 2'b01;
  localparam logic [1:0] MOP_WR  = 2'b10;

  localparam logic [2:0] OPC_COMP = 3'b000;
  localparam logic [2:0] OPC_SHR  = 3'b001;
  localparam logic [2:0] OPC_BRN  = 3'b010;
  localparam logic [2:0] OPC_JMP  = 3'b011;
  localparam logic [2:0] OPC_ST   = 3'b100;
  localparam logic [2:0] OPC_LD   = 3'b101;

  typedef struct packed {
    alu_op_t    alu;
    logic       a_imm;
    logic [1:0] mop;
    pc_sel_t    pcs;
    logic       di_le;
    logic       ac_le;
    logic       ao_le;
    logic       ao_from_x;
  } ctrl_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_t       op,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_NOTB: y = ~b;
      ALU_AND:  y = a & b;
      ALU_ADD:  y = a + b;
      ALU_SHRB: y = {b[DW-1], b[DW-1:1]};
      default:  y = a;
    endcase
  end
endmodule

// File: rtl/acc_pc.sv
module acc_pc
  import acc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  pc_sel_t       sel,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] STEP = {{(AW-2){1'b0}}, 2'b10};

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else begin
      unique case (sel)
        PC_ZERO:  pc <= '0;
        PC_INC:   pc <= pc + STEP;
        PC_LDINC: pc <= din + STEP;
        default:  pc <= pc;
      endcase
    end
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rd_opc,
  input  logic [2:0] di_opc,
  input  logic       ac_neg,
  output ctrl_t      ctl
);
  state_t st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= S_RST1;
    else     st <= st_nx;
  end

  always_comb begin
    ctl   = '{alu: ALU_PASSA, a_imm: 1'b0, mop: MOP_NOP, pcs: PC_HOLD,
              di_le: 1'b0, ac_le: 1'b0, ao_le: 1'b0, ao_from_x: 1'b0};
    st_nx = S_RST1;
    unique case (st)
      S_RST1: begin ctl.pcs = PC_ZERO; st_nx = S_RST2; end
      S_RST2: begin ctl.ao_le = 1'b1; ctl.pcs = PC_INC; st_nx = S_FETCH; end
      S_FETCH: begin
        ctl.mop = MOP_RD; ctl.di_le = 1'b1;
        unique case (rd_opc)
          OPC_COMP, OPC_SHR: st_nx = S_SOPR;
          OPC_BRN:           st_nx = S_BRN1;
          OPC_JMP:           st_nx = S_JMP;
          OPC_ST:            st_nx = S_ST1;
          OPC_LD:            st_nx = S_LD1;
          default:           st_nx = S_AOPR;
        endcase
      end
      S_AOPR, S_SOPR, S_LD3: begin
        if (st == S_AOPR)      ctl.alu = di_opc[0] ? ALU_ADD : ALU_AND;
        else if (st == S_SOPR) ctl.alu = di_opc[0] ? ALU_SHRB : ALU_NOTB;
        ctl.a_imm = (st == S_AOPR);
        ctl.ac_le = 1'b1; ctl.ao_le = 1'b1; ctl.pcs = PC_INC;
        st_nx = S_FETCH;
      end
      S_ST1, S_LD1: begin
        ctl.ao_le = 1'b1; ctl.ao_from_x = 1'b1;
        st_nx = (st == S_ST1) ? S_ST2 : S_LD2;
      end
      S_ST2: begin
        ctl.mop = MOP_WR; ctl.ao_le = 1'b1; ctl.pcs = PC_INC; st_nx = S_FETCH;
      end
      S_LD2: begin ctl.mop = MOP_RD; ctl.di_le = 1'b1; st_nx = S_LD3; end
      S_BRN1: begin
        ctl.ao_le = 1'b1; ctl.pcs = PC_INC;
        st_nx = ac_neg ? S_BRN2 : S_FETCH;
      end
      S_BRN2, S_JMP: begin
        ctl.ao_le = 1'b1; ctl.ao_from_x = 1'b1; ctl.pcs = PC_LDINC;
        st_nx = S_FETCH;
      end
      default: st_nx = S_RST1;
    endcase
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int XW = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] mem_addr,
  output logic [1:0]    mem_op,
  output logic [XW+5:0] mem_wdata,
  input  logic [XW+5:0] mem_rdata
);
  localparam int DW = XW + 6;

  ctrl_t         ctl;
  logic [XW-1:0] pc, abus, ao_q;
  logic [DW-1:0] di_q, ac_q, alu_a, alu_y;

  acc_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .rd_opc(mem_rdata[XW+2:XW]), .di_opc(di_q[XW+2:XW]),
    .ac_neg(ac_q[DW-1]), .ctl(ctl)
  );

  acc_pc #(.AW(XW)) u_pc (
    .clk(clk), .rst(rst), .sel(ctl.pcs), .din(abus), .pc(pc)
  );

  assign abus  = ctl.ao_from_x ? di_q[XW-1:0] : pc;
  assign alu_a = ctl.a_imm ? {{(DW-XW){1'b0}}, di_q[XW-1:0]} : di_q;

  acc_alu #(.DW(DW)) u_alu (.a(alu_a), .b(ac_q), .op(ctl.alu), .y(alu_y));

  always_ff @(posedge clk) begin
    if (rst) begin
      ao_q <= '0;
      di_q <= '0;
      ac_q <= '0;
    end else begin
      if (ctl.ao_le) ao_q <= abus;
      if (ctl.di_le) di_q <= mem_rdata;
      if (ctl.ac_le) ac_q <= alu_y;
    end
  end

  assign mem_addr  = ao_q;
  assign mem_op    = ctl.mop;
  assign mem_wdata = ac_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int XW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mem_op,
  input logic [XW-1:0] mem_addr
);
  a_r9_op_legal: assert property (@(posedge clk) disable iff (rst)
    mem_op != 2'b11);

  a_r9_wr_then_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_op == 2'b10 |=> mem_op == 2'b01);

  a_r6_idle_before_wr: assert property (@(posedge clk) disable iff (rst)
    mem_op == 2'b10 |-> $past(mem_op) == 2'b00);

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_op == 2'b00 && mem_addr == '0));
endmodule

bind acc_core acc_core_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst(rst), .mem_op(mem_op), .mem_addr(mem_addr)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;
  localparam int CLK_NS = 10;
  localparam int MAXN   = 60000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  mem_addr;
  logic [1:0]  mem_op;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [512];

  int checks = 0, fails = 0;
  int tr_op [64];
  int tr_ad [64];
  int n_halt;

  always #(CLK_NS/2) clk = ~clk;

  acc_core u0 (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_op(mem_op),
               .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr[9:1]];
  always @(posedge clk) if (mem_op == 2'b10) mem[mem_addr[9:1]] <= mem_wdata;

  function automatic logic [15:0] ins(input logic [2:0] hi, input logic [2:0] op,
                                      input int x);
    return {hi, op, 10'(x)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 16'h0;
  endtask

  task automatic run(input int halt);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 op in reset", mem_op, 0);
    rst = 1'b0;
    n_halt = -1;
    for (int n = 0; n < MAXN; n++) begin
      #1;
      if (n < 64) begin tr_op[n] = mem_op; tr_ad[n] = mem_addr; end
      if (mem_op == 2'b01 && mem_addr == 10'(halt)) begin n_halt = n; break; end
      @(negedge clk);
    end
    chk("R8 halt reached", n_halt >= 0, 1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // Directed program exercising every instruction
    clear_mem();
    mem[0]  = ins(3'b000, 3'b110, 0);     // AND 0
    mem[1]  = ins(3'b000, 3'b111, 5);     // ADD 5
    mem[2]  = ins(3'b000, 3'b000, 0);     // COMP
    mem[3]  = ins(3'b000, 3'b001, 0);     // SHR
    mem[4]  = ins(3'b000, 3'b100, 900);   // STORE 900
    mem[5]  = ins(3'b000, 3'b010, 20);    // BRN 20 (taken)
    mem[6]  = ins(3'b000, 3'b100, 902);   // skipped
    mem[10] = ins(3'b000, 3'b110, 15);    // AND 15
    mem[11] = ins(3'b000, 3'b010, 30);    // BRN (not taken)
    mem[12] = ins(3'b000, 3'b100, 902);   // STORE 902
    mem[13] = ins(3'b011, 3'b111, 2);     // ADD 2, upper bits set
    mem[14] = ins(3'b100, 3'b100, 904);   // STORE 904, indirect flag set
    mem[15] = ins(3'b000, 3'b101, 900);   // LOAD 900
    mem[16] = ins(3'b000, 3'b001, 0);     // SHR
    mem[17] = ins(3'b000, 3'b100, 906);   // STORE 906
    mem[18] = ins(3'b000, 3'b011, 36);    // JUMP 36 (halt)
    run(36);
    chk("R1 first op idle", tr_op[0], 0);
    chk("R1 first addr zero", tr_ad[0], 0);
    chk("R1 fetch op at n2", tr_op[2], 1);
    chk("R1 fetch addr at n2", tr_ad[2], 0);
    chk("R3 second fetch at n4", tr_ad[4], 2);
    chk("R4 shr fetch at n8", tr_ad[8], 6);
    chk("R6 write op at n12", tr_op[12], 2);
    chk("R6 write addr at n12", tr_ad[12], 900);
    chk("R6 idle before write", tr_op[11], 0);
    chk("R7 taken fetch at n16", tr_ad[16], 20);
    chk("R7 fall-through fetch at n20", tr_ad[20], 24);
    chk("R5 load read op at n30", tr_op[30], 1);
    chk("R5 load read addr at n30", tr_ad[30], 900);
    chk("R9 fetch after write n13", tr_op[13], 1);
    chk("R8 halt cycle", n_halt, 37);
    chk("R4 comp then arith shr", mem[450], 16'hFFFD);
    chk("R3 AND immediate", mem[451], 16'h000D);
    chk("R2 upper bits ignored", mem[452], 16'h000F);
    chk("R5 load then shr", mem[453], 16'hFFFE);
    @(negedge clk); @(negedge clk); #1;
    chk("R8 jump repeats op", mem_op, 1);
    chk("R8 jump repeats addr", mem_addr, 36);

    // Division sweep
    foreach (tr_op[i]) tr_op[i] = 0;
    for (int ia = 0; ia < 6; ia++) begin
      for (int ib = 0; ib < 5; ib++) begin
        int a, b;
        a = (ia == 0) ? 0 : (ia == 1) ? 1 : (ia == 2) ? 9 : (ia == 3) ? 50 :
            (ia == 4) ? 100 : 200;
        b = (ib == 0) ? 1 : (ib == 1) ? 4 : (ib == 2) ? 7 : (ib == 3) ? 13 : 255;
        clear_mem();
        mem[0]  = ins(3'b000, 3'b110, 0);
        mem[1]  = ins(3'b000, 3'b111, a);
        mem[2]  = ins(3'b000, 3'b100, 1000);
        mem[3]  = ins(3'b000, 3'b110, 0);
        mem[4]  = ins(3'b000, 3'b100, 1004);
        mem[5]  = ins(3'b000, 3'b101, 1000);  // loop
        mem[6]  = ins(3'b000, 3'b000, 0);
        mem[7]  = ins(3'b000, 3'b111, b);
        mem[8]  = ins(3'b000, 3'b000, 0);     // AC = a - b
        mem[9]  = ins(3'b000, 3'b010, 30);
        mem[10] = ins(3'b000, 3'b100, 1000);
        mem[11] = ins(3'b000, 3'b101, 1004);
        mem[12] = ins(3'b000, 3'b111, 1);
        mem[13] = ins(3'b000, 3'b100, 1004);
        mem[14] = ins(3'b000, 3'b011, 10);
        mem[15] = ins(3'b000, 3'b011, 30);
        run(30);
        chk($sformatf("R10 quotient %0d/%0d", a, b), mem[502], a / b);
        chk($sformatf("R10 remainder %0d/%0d", a, b), mem[500], a % b);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule